// File: doc/BRIEF.md
# Quarter-Wave Sine/Cosine Phase-to-Amplitude Converter

This block turns a truncated phase word from a phase accumulator into two signed amplitude samples, one in phase and one in quadrature. It reads a single quarter of a sine period from a small table. It reaches the other three quarters by mirroring: for phase reversal it complements the in-quadrant address, and for amplitude reversal it complements the magnitude. Each output channel has its own quarter table. The quadrature channel adds a quarter turn to the phase before it folds the phase.

The table samples sit half a step away from both 0° and 90°. Sample `p` of a full period therefore lies at angle 2π(p+0.5)/256. The mirrored quarters then join with no repeated end value. The sign is split symmetrically: magnitude `m` becomes `+m` or `-m-1`, so the output is centred on −0.5 LSB. Besides the sine, a mode select sends out the folded address directly as a triangle, or produces a square wave from the phase sign bit. Both outputs are registered and appear two clocks after their inputs.

Top module: `quad_sine_lut`

## Requirements
- R1: While `rst_n` is low, `sin_out` and `cos_out` are zero from the clock edge after the first low sample.
- R2: A `phase_in`/`wave_sel` pair sampled at clock edge k determines both outputs after edge k+1 and not earlier; the output after edge k still reflects the previous pair.
- R3: In sine mode (`wave_sel` = 2'b00), `sin_out` for phase p has magnitude m = round(127·|sin(2π(p+0.5)/256)|).
- R4: Sign encoding on both outputs: a positive half gives `+m`, a negative half gives `-m-1` (two's complement, bitwise complement of m). The sign bit of `sin_out` equals bit 7 of the phase in every mode.
- R5: `cos_out` for phase p equals `sin_out` for phase (p+64) mod 256 in every mode. Its sign bit is phase bit 7 XOR phase bit 6.
- R6: In triangle mode (`wave_sel` = 2'b01), the magnitude is 2a+1, where a is phase bits 5:0 XOR-ed with phase bit 6. The sign follows R4, so the LSB of the output always differs from its sign bit.
- R7: In square mode, the output is +127 when phase bit 7 is 0 and −128 when it is 1.
- R8: Mode codes: 2'b00 is sine, 2'b01 is triangle, and any code with bit 1 set (2'b10, 2'b11) is square.
- R9: Odd symmetry: the output for phase p XOR 128 is the bitwise complement of the output for phase p.
- R10: Mirror symmetry about the quarter point: in sine mode the output for phase p equals the output for phase 127−p (p < 128). The largest positive value 127 occurs at phases 63 and 64, and phase 0 gives the smallest positive value, 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_in | input | 8 | Truncated phase word, one full period over 256 codes |
| wave_sel | input | 2 | Waveform select: 00 sine, 01 triangle, 1x square |
| sin_out | output | 8 | In-phase two's-complement sample |
| cos_out | output | 8 | Quadrature two's-complement sample |

## Verification
The bench builds the block with its default widths: an 8-bit phase and 8-bit amplitude. With these widths all 256 phase codes can be swept exhaustively in every mode. Each sample is compared against a rounded real-valued sine or cosine and an independently computed triangle. The full sweep also exposes the mirror, odd-symmetry and quarter-shift relations between recorded samples. Those relations would catch an off-by-one in the half-step fold or in the quadrant offset that a spot check could miss.

// File: rtl/qsl_pkg.sv
`timescale 1ns/1ps
package qsl_pkg;

  // Waveform select codes; any code with bit 1 set means square.
  localparam logic [1:0] MODE_SINE = 2'b00;
  localparam logic [1:0] MODE_TRI  = 2'b01;

  // Rounded magnitude of sin((idx+0.5) * (pi/2) / depth) scaled to mag_max.
  // Fixed-point Taylor series in Q30, evaluated at elaboration.
  function automatic int quarter_sine_mag(input int idx, input int depth,
                                          input int mag_max);
    longint pi_q30;
    longint x;
    longint term;
    longint acc;
    longint t1;
    longint t2;
    longint mag;
    pi_q30 = 64'sd3373259426;
    x      = (longint'(2 * idx + 1) * pi_q30) / longint'(4 * depth);
    acc    = x;
    term   = x;
    for (int k = 1; k <= 7; k++) begin
      t1   = (term * x) >>> 30;
      t2   = (t1 * x) >>> 30;
      term = -(t2 / longint'((2 * k) * (2 * k + 1)));
      acc  = acc + term;
    end
    mag = (acc * longint'(mag_max) + (64'sd1 <<< 29)) >>> 30;
    if (mag > longint'(mag_max)) mag = longint'(mag_max);
    if (mag < 0) mag = 0;
    return int'(mag);
  endfunction

endpackage

// File: rtl/qsl_fold.sv
`timescale 1ns/1ps
// Splits a phase word into a half-period sign and a mirrored in-quadrant address.
module qsl_fold #(
  parameter int PHASE_W = 8,
  localparam int ADDR_W = PHASE_W - 2
) (
  input  logic [PHASE_W-1:0] phase,
  output logic               neg,
  output logic [ADDR_W-1:0]  addr
);
  logic quad_odd;

  assign neg      = phase[PHASE_W-1];
  assign quad_odd = phase[PHASE_W-2];
  assign addr     = phase[ADDR_W-1:0] ^ {ADDR_W{quad_odd}};
endmodule

// File: rtl/qsl_quarter_rom.sv
`timescale 1ns/1ps
// One quadrant of sine magnitudes, sampled half a step off both ends.
module qsl_quarter_rom #(
  parameter int ADDR_W = 6,
  parameter int MAG_W  = 7,
  localparam int DEPTH   = 1 << ADDR_W,
  localparam int MAG_MAX = (1 << MAG_W) - 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [MAG_W-1:0]  mag
);
  logic [MAG_W-1:0] tbl [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    localparam int VAL = qsl_pkg::quarter_sine_mag(gi, DEPTH, MAG_MAX);
    assign tbl[gi] = MAG_W'(VAL);
  end

  assign mag = tbl[addr];
endmodule

// File: rtl/qsl_channel.sv
`timescale 1ns/1ps
// One output channel: phase offset, fold, table, waveform select, sign.
module qsl_channel #(
  parameter int PHASE_W = 8,
  parameter int AMP_W   = 8,
  parameter int OFFSET  = 0,
  localparam int ADDR_W = PHASE_W - 2,
  localparam int MAG_W  = AMP_W - 1,
  localparam int TRI_W  = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase,
  input  logic [1:0]         mode,
  output logic [AMP_W-1:0]   sample
);
  import qsl_pkg::*;

  logic [PHASE_W-1:0] ph_shift;
  logic               f_neg;
  logic [ADDR_W-1:0]  f_addr;

  // Stage 1 registers
  logic               s1_neg;
  logic [ADDR_W-1:0]  s1_addr;
  logic [1:0]         s1_mode;

  logic [MAG_W-1:0]   rom_mag;
  logic [MAG_W-1:0]   tri_mag;
  logic [MAG_W-1:0]   sel_mag;
  logic [AMP_W-1:0]   signed_val;

  function automatic logic [AMP_W-1:0] apply_sign(input logic n,
                                                  input logic [MAG_W-1:0] m);
    // +m for the positive half, -m-1 (= ~m) for the negative half
    return n ? ~{1'b0, m} : {1'b0, m};
  endfunction

  assign ph_shift = phase + PHASE_W'(OFFSET);

  qsl_fold #(.PHASE_W(PHASE_W)) u_fold (
    .phase (ph_shift),
    .neg   (f_neg),
    .addr  (f_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_neg  <= 1'b0;
      s1_addr <= '0;
      s1_mode <= MODE_SINE;
    end else begin
      s1_neg  <= f_neg;
      s1_addr <= f_addr;
      s1_mode <= mode;
    end
  end

  qsl_quarter_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
    .addr (s1_addr),
    .mag  (rom_mag)
  );

  // Triangle: folded address as an odd code 2a+1, scaled to the magnitude width
  if (MAG_W >= TRI_W) begin : g_tri_wide
    assign tri_mag = MAG_W'({s1_addr, 1'b1}) << (MAG_W - TRI_W);
  end else begin : g_tri_narrow
    assign tri_mag = MAG_W'({s1_addr, 1'b1} >> (TRI_W - MAG_W));
  end

  always_comb begin
    if (s1_mode[1])               sel_mag = {MAG_W{1'b1}};
    else if (s1_mode == MODE_TRI) sel_mag = tri_mag;
    else                          sel_mag = rom_mag;
  end

  assign signed_val = apply_sign(s1_neg, sel_mag);

  always_ff @(posedge clk) begin
    if (!rst_n) sample <= '0;
    else        sample <= signed_val;
  end
endmodule

// File: rtl/quad_sine_lut.sv
`timescale 1ns/1ps
// Quadrature phase-to-amplitude converter built from two quarter-wave channels.
module quad_sine_lut #(
  parameter int PHASE_W = 8,
  parameter int AMP_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase_in,
  input  logic [1:0]         wave_sel,
  output logic [AMP_W-1:0]   sin_out,
  output logic [AMP_W-1:0]   cos_out
);
  localparam int N_CH    = 2;
  localparam int QUARTER = 1 << (PHASE_W - 2);

  logic [AMP_W-1:0] ch_out [N_CH];

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    qsl_channel #(
      .PHASE_W (PHASE_W),
      .AMP_W   (AMP_W),
      .OFFSET  (ch * QUARTER)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .phase  (phase_in),
      .mode   (wave_sel),
      .sample (ch_out[ch])
    );
  end

  assign sin_out = ch_out[0];
  assign cos_out = ch_out[1];
endmodule

// File: rtl/quad_sine_lut_chk.sv
`timescale 1ns/1ps
module quad_sine_lut_chk #(
  parameter int PHASE_W = 8,
  parameter int AMP_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PHASE_W-1:0] phase_in,
  input logic [1:0]         wave_sel,
  input logic [AMP_W-1:0]   sin_out,
  input logic [AMP_W-1:0]   cos_out
);
  localparam logic [AMP_W-1:0] POS_RAIL = {1'b0, {(AMP_W-1){1'b1}}};
  localparam logic [AMP_W-1:0] NEG_RAIL = {1'b1, {(AMP_W-1){1'b0}}};

  logic [1:0]         live_cnt;
  logic [PHASE_W-1:0] ph_d1, ph_d2;
  logic [1:0]         md_d1, md_d2;
  logic               primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_cnt <= '0;
      ph_d1 <= '0; ph_d2 <= '0;
      md_d1 <= '0; md_d2 <= '0;
    end else begin
      if (live_cnt != 2'd2) live_cnt <= live_cnt + 2'd1;
      ph_d1 <= phase_in; ph_d2 <= ph_d1;
      md_d1 <= wave_sel; md_d2 <= md_d1;
    end
  end

  assign primed = (live_cnt == 2'd2);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (sin_out == '0 && cos_out == '0)); // R1

  AST_SIN_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (sin_out[AMP_W-1] == ph_d2[PHASE_W-1])); // R4

  AST_COS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (cos_out[AMP_W-1] == (ph_d2[PHASE_W-1] ^ ph_d2[PHASE_W-2]))); // R5

  AST_SQUARE_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && md_d2[1]) |-> ((sin_out == POS_RAIL || sin_out == NEG_RAIL) &&
                              (cos_out == POS_RAIL || cos_out == NEG_RAIL))); // R7

  AST_TRI_ODD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && md_d2 == 2'b01) |-> (sin_out[0] != sin_out[AMP_W-1])); // R6
endmodule

bind quad_sine_lut quad_sine_lut_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (.*);

// File: tb/sim_quad_sine_lut.sv
`timescale 1ns/1ps
module sim_quad_sine_lut;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] phase_in = '0;
  logic [1:0] wave_sel = '0;
  logic [7:0] sin_out, cos_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] rec_i [256];
  logic [7:0] rec_q [256];

  always #4 clk = ~clk;

  quad_sine_lut u0 (
    .clk (clk), .rst_n (rst_n), .phase_in (phase_in),
    .wave_sel (wave_sel), .sin_out (sin_out), .cos_out (cos_out)
  );

  function automatic logic [7:0] encode(input bit negative, input int m);
    return negative ? 8'(-m - 1) : 8'(m);
  endfunction

  function automatic logic [7:0] ref_trig(input int p, input bit use_cos);
    real a, s;
    int m;
    a = 2.0 * 3.14159265358979 * (real'(p) + 0.5) / 256.0;
    s = use_cos ? $cos(a) : $sin(a);
    m = int'($floor(127.0 * (s < 0.0 ? -s : s) + 0.5));
    return encode(s < 0.0, m);
  endfunction

  function automatic logic [7:0] ref_tri(input int p);
    int pos, m;
    pos = p % 128;
    m = (pos < 64) ? 2 * pos + 1 : 2 * (127 - pos) + 1;
    return encode(p >= 128, m);
  endfunction

  function automatic logic [7:0] ref_out(input int p, input int mode, input bit quad);
    int pp;
    pp = quad ? (p + 64) % 256 : p;
    if (mode >= 2) return (pp >= 128) ? 8'h80 : 8'h7f;
    if (mode == 1) return ref_tri(pp);
    return ref_trig(p, quad);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d", req, $signed(got), $signed(exp));
    end
  endtask

  task automatic apply(input int p, input int mode);
    @(negedge clk);
    phase_in = 8'(p);
    wave_sel = 2'(mode);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1ms;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check("R1 sin", sin_out, 8'h00);
    check("R1 cos", cos_out, 8'h00);
    rst_n = 1'b1;

    // R3, R4, R5: sine sweep of every phase
    for (int p = 0; p < 256; p++) begin
      apply(p, 0);
      rec_i[p] = sin_out;
      rec_q[p] = cos_out;
      check("R3 R4 sin", sin_out, ref_out(p, 0, 1'b0));
      check("R5 cos", cos_out, ref_out(p, 0, 1'b1));
    end

    // R5, R9, R10: relations between recorded samples
    for (int p = 0; p < 256; p++) begin
      check("R5 quad shift", rec_q[p], rec_i[(p + 64) % 256]);
      check("R9 odd symmetry", rec_i[p ^ 128], ~rec_i[p]);
    end
    for (int p = 0; p < 128; p++)
      check("R10 mirror", rec_i[p], rec_i[127 - p]);
    check("R10 peak 63", rec_i[63], 8'd127);
    check("R10 peak 64", rec_i[64], 8'd127);
    check("R10 phase 0", rec_i[0], 8'd2);

    // R6: triangle sweep
    for (int p = 0; p < 256; p++) begin
      apply(p, 1);
      check("R6 tri sin", sin_out, ref_tri(p));
      check("R6 R5 tri cos", cos_out, ref_tri((p + 64) % 256));
    end

    // R7, R8: both square codes
    for (int mode = 2; mode < 4; mode++) begin
      for (int p = 0; p < 256; p += 5) begin
        apply(p, mode);
        check("R7 R8 square sin", sin_out, (p >= 128) ? 8'h80 : 8'h7f);
        check("R7 R8 square cos", cos_out, ref_out(p, mode, 1'b1));
      end
    end

    // R2: latency of two clocks
    @(negedge clk);
    phase_in = 8'd10; wave_sel = 2'd0;
    repeat (3) @(negedge clk);
    phase_in = 8'd200; wave_sel = 2'd1;
    @(negedge clk);
    check("R2 old value held", sin_out, ref_out(10, 0, 1'b0));
    @(negedge clk);
    check("R2 new value", sin_out, ref_out(200, 1, 1'b0));
    check("R2 new value cos", cos_out, ref_out(200, 1, 1'b1));

    // Random mix of phases and modes (R3 R5 R6 R7 R8)
    void'($urandom(32'd1357));
    for (int n = 0; n < 400; n++) begin
      int p, mode;
      p = int'($urandom % 256);
      mode = int'($urandom % 4);
      apply(p, mode);
      check("R3 R6 R7 R8 random sin", sin_out, ref_out(p, mode, 1'b0));
      check("R5 random cos", cos_out, ref_out(p, mode, 1'b1));
    end

    // R1: reset again in mid-run
    @(negedge clk);
    phase_in = 8'd40;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 sin again", sin_out, 8'h00);
    check("R1 cos again", cos_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end
endmodule